// File: doc/BRIEF.md
# Tagged Packet Address Generator

This block turns a packet request, named by a tag, into a run of local-bus word addresses. Each tag index owns three table entries: a first address, a resume address and a word count.

A request with a plain tag loads a running counter from the tag's first address. A request with the resume bit set loads the counter from the tag's resume address instead. The generator then offers one address per data word and steps the counter after each acknowledged word. After every step it writes the new counter value back into the tag's resume entry.

A structure longer than one packet is therefore moved as a plain packet followed by resume packets, with no address arithmetic by the host. The structure has to be a whole multiple of the packet length. For example, a 260-word structure goes as two 130-word packets.

The host fills the first-address and word-count tables through a programming port and can read all three tables back. Only the generator can change the resume table. Data movement is outside this block.

Top module: `tagged_pkt_addr_gen`

## Requirements
- R1: The host writes the first-address table (cfg_sel=0, 32 bits) and the word-count table (cfg_sel=1, 12 bits, upper write bits dropped), 512 entries each, indexed by cfg_idx. A read with cfg_re returns the chosen entry on cfg_rdata one cycle later: sel 0 is the first address, sel 1 is the count zero-extended, sel 2 is the resume address.
- R2: A tag whose bit 11 is 0 and whose bits 10:9 are 0 is a plain tag with index tag[8:0]. Its first address offered is the index's first-address entry.
- R3: A tag with bit 11 set (tag = index + 2048) and bits 10:9 at 0 resumes: its first address offered is the index's resume entry.
- R4: acc_valid rises in the second cycle after an accepted request. Each word with acc_valid and acc_ready high at a clock edge is consumed, and the next address is the previous one plus 1, wrapping modulo 2^32. While acc_ready is low, the address holds.
- R5: After every consumed word the resume entry holds that word's address plus 1. After a packet of N words it holds the packet's first address plus N.
- R6: Host writes with cfg_sel=2 have no effect on the resume table.
- R7: A word count of zero ends the packet with no address offered and leaves the resume entry unchanged.
- R8: A tag with bit 9 or bit 10 set is rejected: req_err pulses for one cycle in the cycle after the request, busy stays low and no address is offered.
- R9: busy is high from the cycle after an accepted request until the edge that consumes the last word. Requests made while busy are ignored.
- R10: pkt_done pulses for one cycle right after the edge that consumes the last word, or after the load cycle for a zero count, with busy already low.
- R11: A plain packet followed by resume packets of the same index yields one contiguous address run across the whole structure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_re | input | 1 | Table read strobe |
| cfg_sel | input | 2 | Table select: 0 first address, 1 word count, 2 resume address |
| cfg_idx | input | 9 | Table entry index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid one cycle after cfg_re |
| req_valid | input | 1 | Packet request strobe |
| req_tag | input | 12 | Packet tag |
| busy | output | 1 | Packet in progress |
| req_err | output | 1 | One-cycle pulse after a rejected tag |
| pkt_done | output | 1 | One-cycle pulse when a packet completes |
| acc_valid | output | 1 | Address is offered |
| acc_addr | output | 32 | Word address |
| acc_ready | input | 1 | Word consumed at this edge |

## Verification
The bench sets a 130-word packet to run into a resume packet. A design that resumed from the first address, or stored the address before the step, would repeat a word or skip one at the seam.

It holds acc_ready low at random. A design that stepped on offered rather than consumed words would race ahead of the data.

It also covers three further cases:
- A zero-count resume must leave the stored address alone and offer nothing.
- Tags with the reserved bits set must raise only req_err; a design that masked those bits would start a packet.
- A request made in the load cycle must not restart the packet.

A counter placed next to the top of the address space checks the wrap to zero.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_LOAD = 2'd1,
    PG_RUN  = 2'd2
  } pag_state_e;

  typedef enum logic [1:0] {
    TBL_FIRST  = 2'd0,
    TBL_COUNT  = 2'd1,
    TBL_RESUME = 2'd2
  } pag_tbl_e;
endpackage

// File: rtl/pag_rst_sync.sv
module pag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pag_ram.sv
module pag_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/pag_tag_decode.sv
module pag_tag_decode #(
  parameter int TAG_W = 12,
  parameter int IDX_W = 9
) (
  input  logic [TAG_W-1:0] tag,
  output logic [IDX_W-1:0] idx,
  output logic             resume,
  output logic             bad
);
  localparam int RESUME_BIT = TAG_W - 1;

  assign idx    = tag[IDX_W-1:0];
  assign resume = tag[RESUME_BIT];

  generate
    if (RESUME_BIT > IDX_W) begin : g_gap
      assign bad = |tag[RESUME_BIT-1:IDX_W];
    end else begin : g_nogap
      assign bad = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pag_engine.sv
module pag_engine
  import pag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              req_resume,
  input  logic              req_bad,
  output logic [IDX_W-1:0]  eng_idx,
  input  logic [ADDR_W-1:0] first_rd,
  input  logic [ADDR_W-1:0] resume_rd,
  input  logic [SIZE_W-1:0] count_rd,
  output logic              resume_we,
  output logic [ADDR_W-1:0] resume_wdata,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_ready,
  output logic              busy,
  output logic              pkt_done,
  output logic              req_err
);
  pag_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              res_q, res_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [SIZE_W-1:0] left_q, left_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              take_en, cnt_en;
  logic              step;

  assign step = (state_q == PG_RUN) && acc_ready;

  always_comb begin
    state_d      = state_q;
    idx_d        = idx_q;
    res_d        = res_q;
    cnt_d        = cnt_q;
    left_d       = left_q;
    done_d       = 1'b0;
    err_d        = 1'b0;
    take_en      = 1'b0;
    cnt_en       = 1'b0;
    resume_we    = 1'b0;
    resume_wdata = cnt_q + ADDR_W'(1);
    unique case (state_q)
      PG_IDLE: begin
        if (req_valid) begin
          if (req_bad) begin
            err_d = 1'b1;
          end else begin
            take_en = 1'b1;
            idx_d   = req_idx;
            res_d   = req_resume;
            state_d = PG_LOAD;
          end
        end
      end
      PG_LOAD: begin
        cnt_en = 1'b1;
        cnt_d  = res_q ? resume_rd : first_rd;
        left_d = count_rd;
        if (count_rd == '0) begin
          done_d  = 1'b1;
          state_d = PG_IDLE;
        end else begin
          state_d = PG_RUN;
        end
      end
      PG_RUN: begin
        if (step) begin
          cnt_en    = 1'b1;
          cnt_d     = cnt_q + ADDR_W'(1);
          left_d    = left_q - SIZE_W'(1);
          resume_we = 1'b1;
          if (left_q == SIZE_W'(1)) begin
            done_d  = 1'b1;
            state_d = PG_IDLE;
          end
        end
      end
      default: state_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      idx_q   <= '0;
      res_q   <= 1'b0;
      cnt_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (take_en) begin
        idx_q <= idx_d;
        res_q <= res_d;
      end
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        left_q <= left_d;
      end
    end
  end

  assign eng_idx   = idx_q;
  assign acc_valid = (state_q == PG_RUN);
  assign acc_addr  = cnt_q;
  assign busy      = (state_q != PG_IDLE);
  assign pkt_done  = done_q;
  assign req_err   = err_q;
endmodule

// File: rtl/tagged_pkt_addr_gen.sv
module tagged_pkt_addr_gen
  import pag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 12,
  parameter int ENTRIES = 512,
  parameter int TAG_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              busy,
  output logic              req_err,
  output logic              pkt_done,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_ready
);
  logic              rst_i_n;
  logic [IDX_W-1:0]  dec_idx, eng_idx;
  logic              dec_resume, dec_bad;
  logic [ADDR_W-1:0] first_eng, first_host;
  logic [ADDR_W-1:0] resume_eng, resume_host;
  logic [SIZE_W-1:0] count_eng, count_host;
  logic              resume_we;
  logic [ADDR_W-1:0] resume_wdata;
  logic              first_we, count_we;
  logic [ADDR_W-1:0] rdata_q, rdata_d;

  pag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  pag_tag_decode #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_dec (
    .tag(req_tag), .idx(dec_idx), .resume(dec_resume), .bad(dec_bad)
  );

  assign first_we = cfg_we && (cfg_sel == TBL_FIRST);
  assign count_we = cfg_we && (cfg_sel == TBL_COUNT);

  pag_ram #(.WIDTH(ADDR_W), .DEPTH(ENTRIES)) u_first (
    .clk(clk), .we(first_we), .waddr(cfg_idx), .wdata(cfg_wdata),
    .raddr_a(eng_idx), .rdata_a(first_eng),
    .raddr_b(cfg_idx), .rdata_b(first_host)
  );

  pag_ram #(.WIDTH(SIZE_W), .DEPTH(ENTRIES)) u_count (
    .clk(clk), .we(count_we), .waddr(cfg_idx), .wdata(cfg_wdata[SIZE_W-1:0]),
    .raddr_a(eng_idx), .rdata_a(count_eng),
    .raddr_b(cfg_idx), .rdata_b(count_host)
  );

  pag_ram #(.WIDTH(ADDR_W), .DEPTH(ENTRIES)) u_resume (
    .clk(clk), .we(resume_we), .waddr(eng_idx), .wdata(resume_wdata),
    .raddr_a(eng_idx), .rdata_a(resume_eng),
    .raddr_b(cfg_idx), .rdata_b(resume_host)
  );

  pag_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_i_n),
    .req_valid(req_valid), .req_idx(dec_idx), .req_resume(dec_resume), .req_bad(dec_bad),
    .eng_idx(eng_idx),
    .first_rd(first_eng), .resume_rd(resume_eng), .count_rd(count_eng),
    .resume_we(resume_we), .resume_wdata(resume_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_ready(acc_ready),
    .busy(busy), .pkt_done(pkt_done), .req_err(req_err)
  );

  always_comb begin
    unique case (cfg_sel)
      TBL_FIRST:  rdata_d = first_host;
      TBL_COUNT:  rdata_d = ADDR_W'(count_host);
      TBL_RESUME: rdata_d = resume_host;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    rdata_q <= '0;
    else if (cfg_re) rdata_q <= rdata_d;
  end

  assign cfg_rdata = rdata_q;
endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              req_err,
  input logic              pkt_done,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_ready
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> !acc_valid || (acc_addr == $past(acc_addr) + ADDR_W'(1))); // R4

  AST_ADDR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> busy); // R9

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R9

  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid) && !busy && !acc_valid); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> !busy && !acc_valid); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done); // R10
endmodule

bind tagged_pkt_addr_gen pag_checker #(.ADDR_W(ADDR_W)) u_pag_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .req_err(req_err), .pkt_done(pkt_done), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .acc_ready(acc_ready)
);

// File: tb/tb_tagged_pkt_addr_gen.sv
`timescale 1ns/1ps
module tb_tagged_pkt_addr_gen;
  logic        clk;
  logic        rst_n;
  logic        cfg_we, cfg_re;
  logic [1:0]  cfg_sel;
  logic [8:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic [11:0] req_tag;
  logic        busy, req_err, pkt_done, acc_valid;
  logic [31:0] acc_addr;
  logic        acc_ready;

  int nvec = 0;
  int nfail = 0;

  logic [31:0] m_first  [512];
  logic [11:0] m_count  [512];
  logic [31:0] m_resume [512];

  tagged_pkt_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_tag(req_tag),
    .busy(busy), .req_err(req_err), .pkt_done(pkt_done),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_ready(acc_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [11:0] plain_tag(input logic [8:0] idx);
    return {3'b000, idx};
  endfunction

  function automatic logic [11:0] resume_tag(input logic [8:0] idx);
    return 12'd2048 + {3'b000, idx};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [8:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_first[idx] = d;
    if (sel == 2'd1) m_count[idx] = d[11:0];
  endtask

  task automatic host_rd(input string req, input logic [1:0] sel, input logic [8:0] idx,
                         input logic [31:0] exp);
    @(negedge clk);
    cfg_re = 1'b1; cfg_sel = sel; cfg_idx = idx;
    @(negedge clk);
    cfg_re = 1'b0;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic run_pkt(input logic [11:0] tag);
    logic [8:0]  idx;
    logic [31:0] base;
    int          n;
    int          sz;
    int          guard;
    idx  = tag[8:0];
    base = tag[11] ? m_resume[idx] : m_first[idx];
    sz   = int'(m_count[idx]);
    @(negedge clk);
    req_valid = 1'b1; req_tag = tag;
    @(negedge clk);
    chk("R9 busy after request", {31'd0, busy}, 32'd1);
    chk("R4 no address in load cycle", {31'd0, acc_valid}, 32'd0);
    req_tag = plain_tag(9'd300);
    n = 0; guard = 0;
    while (n < sz && guard < 2000) begin
      @(negedge clk);
      req_valid = 1'b0;
      guard++;
      chk(tag[11] ? "R3 R4 R11 address" : "R2 R4 address", acc_addr, base + 32'(n));
      chk("R9 busy during packet", {31'd0, busy & acc_valid}, 32'd1);
      acc_ready = ($urandom % 4) != 0;
      if (acc_ready) n++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    acc_ready = 1'b0;
    chk(sz == 0 ? "R7 R10 done on zero count" : "R10 done pulse", {31'd0, pkt_done}, 32'd1);
    chk("R9 idle after last word", {30'd0, busy, acc_valid}, 32'd0);
    if (sz != 0) m_resume[idx] = base + 32'(sz);
    host_rd(sz == 0 ? "R7 resume unchanged" : "R5 resume after packet", 2'd2, idx, m_resume[idx]);
  endtask

  task automatic bad_req(input logic [11:0] tag);
    @(negedge clk);
    req_valid = 1'b1; req_tag = tag;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 error pulse", {31'd0, req_err}, 32'd1);
    chk("R8 stays idle", {30'd0, busy, acc_valid}, 32'd0);
    @(negedge clk);
    chk("R8 error one cycle", {29'd0, req_err, busy, acc_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_re = 1'b0; cfg_sel = 2'd0; cfg_idx = '0;
    cfg_wdata = '0; req_valid = 1'b0; req_tag = '0; acc_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset done", {31'd0, pkt_done}, 32'd0);
    chk("R8 reset err", {31'd0, req_err}, 32'd0);
    chk("R4 reset valid", {31'd0, acc_valid}, 32'd0);
    chk("R1 reset rdata", cfg_rdata, 32'd0);

    // R1 table programming and readback
    host_wr(2'd0, 9'd5, 32'h1000_0400);
    host_wr(2'd1, 9'd5, 32'hFFFF_F082);
    host_rd("R1 first readback", 2'd0, 9'd5, 32'h1000_0400);
    host_rd("R1 count readback", 2'd1, 9'd5, 32'd130);

    // R11 260-word structure as two 130-word packets
    run_pkt(plain_tag(9'd5));
    run_pkt(resume_tag(9'd5));
    chk("R11 seam", m_resume[5], 32'h1000_0400 + 32'd260);

    // R6 host cannot alter resume table
    host_wr(2'd2, 9'd5, 32'hDEAD_BEEF);
    host_rd("R6 resume write ignored", 2'd2, 9'd5, m_resume[5]);

    // R7 zero count on resume
    host_wr(2'd0, 9'd7, 32'h0000_0040);
    host_wr(2'd1, 9'd7, 32'd3);
    run_pkt(plain_tag(9'd7));
    host_wr(2'd1, 9'd7, 32'd0);
    run_pkt(resume_tag(9'd7));
    run_pkt(plain_tag(9'd7));

    // R4 wrap at top of space
    host_wr(2'd0, 9'd9, 32'hFFFF_FFFE);
    host_wr(2'd1, 9'd9, 32'd4);
    run_pkt(plain_tag(9'd9));

    // highest index
    host_wr(2'd0, 9'd511, 32'h0ABC_0000);
    host_wr(2'd1, 9'd511, 32'd1);
    run_pkt(plain_tag(9'd511));
    run_pkt(resume_tag(9'd511));

    // R8 reserved tag bits
    bad_req(12'h200);
    bad_req(12'h405);
    bad_req(12'hE05);
    host_rd("R8 resume untouched", 2'd2, 9'd5, m_resume[5]);

    // random packets
    for (int i = 0; i < 24; i++) begin
      logic [8:0] ix;
      ix = 9'(16 + ($urandom % 16));
      host_wr(2'd0, ix, $urandom);
      host_wr(2'd1, ix, 32'(1 + ($urandom % 12)));
      run_pkt(plain_tag(ix));
      if (($urandom % 2) == 0) run_pkt(resume_tag(ix));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule